// File: doc/BRIEF.md
# Endpoint FIFO RAM allocator

This block places the packet FIFOs of a USB function controller inside one shared 4096-byte RAM. Endpoint 0 has a fixed 64-byte FIFO at address 0. Endpoints 1 to 4 each have a transmit and a receive FIFO. Software sets three things for each of these FIFOs: where it starts, how large its packets can be, and whether it holds two packet buffers instead of one. At run time the FIFO logic presents an endpoint, a direction, a byte offset and a buffer select. The block answers one cycle later with a physical RAM address, or with a refusal when the offset falls outside the packet.

Software reaches the sizing fields through a small indexed window. It writes the endpoint number into an index register, and then the start and size registers of the window refer to that endpoint. The block also watches the whole layout continuously. It latches an error flag when an enabled FIFO runs past the end of the RAM or shares bytes with another enabled FIFO, and endpoint 0's fixed region takes part in that check.

Top module: `ep_fifo_alloc`

## Requirements
- R1: After reset the index register reads 0. Every FIFO of endpoints 1 to 4 reads start 0, size code 0, single-buffered and disabled. `cfgErr`, `ramEn` and `rangeErr` are low.
- R2: The window has these register offsets: 0 is the index, 1 is the transmit start, 2 is the transmit size, 3 is the receive start and 4 is the receive size. Offsets 5 to 7 read 0. A write to offsets 1 to 4 updates the FIFO of the endpoint held in the index register. A start is 9 bits in 8-byte units. A size register holds the size code n in bits 2:0 (packet size 8<<n bytes, 8 to 1024), the double-buffer flag in bit 4 and the enable flag in bit 7. All fields read back as written.
- R3: With index 0, the start registers read 0 and the size registers read 0x83 (enabled, 64 bytes, single). Writes to them have no effect. With an index of 5 to 7, offsets 1 to 4 read 0 and writes change no FIFO.
- R4: One cycle after `accValid` with an in-range request, `ramEn` is high and `ramAddr` equals start×8 plus the offset. When `accValid` is low, `ramEn` and `rangeErr` are low in the following cycle.
- R5: For a double-buffered FIFO, buffer select 1 adds one packet size to the address. For a single-buffered FIFO, buffer select has no effect.
- R6: A request for endpoint 0 maps to the offset itself, with a 64-byte packet limit, and buffer select is ignored.
- R7: A request whose offset is at or above the packet size, or whose endpoint is above 4, is blocked. In the next cycle `ramEn` is low, `ramAddr` is 0 and `rangeErr` is high for exactly one cycle.
- R8: `cfgErr` rises one cycle after a configuration write leaves an enabled FIFO ending beyond byte 4096. A FIFO that ends exactly at 4096 is legal. A double-buffered FIFO spans twice its packet size.
- R9: `cfgErr` rises one cycle after any two enabled regions share a byte. The regions include endpoint 0's [0,64) and both directions of the same endpoint. Regions that only touch at an edge are legal.
- R10: Disabled FIFOs take no part in the checks. Once set, `cfgErr` stays high until reset, even after the layout is corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register window write strobe |
| regAddr | input | 3 | Register window offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| accValid | input | 1 | FIFO access request |
| accEp | input | 3 | Endpoint of the request |
| accDir | input | 1 | 0 transmit, 1 receive |
| accOffset | input | 11 | Byte offset inside the packet buffer |
| accBufSel | input | 1 | Buffer select for double-buffered FIFOs |
| ramEn | output | 1 | Registered RAM enable |
| ramAddr | output | 12 | Registered physical RAM address |
| rangeErr | output | 1 | One-cycle flag for a blocked request |
| cfgErr | output | 1 | Sticky layout error flag |

## Verification
The hardest case to reach is a layout fault that exists only because of double-buffering. A region is clean while it is single-buffered and collides with its neighbour only when its span doubles. The bench first builds two neighbouring regions of one endpoint and confirms the flag stays low. It then sets only the double-buffer bit and expects the flag one cycle later. The legal limits are approached the same way: a FIFO ending exactly at byte 4096 and regions that only touch must leave the flag low. The over-end case is staged while the FIFO is still disabled, so that enabling it alone sets the flag.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  localparam int unsigned RAM_BYTES  = 4096;
  localparam int unsigned UNIT_BYTES = 8;
  localparam int unsigned NUM_DYN_EP = 4;
  localparam int unsigned EP0_BYTES  = 64;
  localparam int unsigned MAX_CODE   = 7;
  localparam int unsigned ADDR_W     = $clog2(RAM_BYTES);
  localparam int unsigned UNIT_SH    = $clog2(UNIT_BYTES);
  localparam int unsigned START_W    = ADDR_W - UNIT_SH;
  localparam int unsigned CODE_W     = $clog2(MAX_CODE + 1);
  localparam int unsigned EP_W       = 3;
  localparam int unsigned OFF_W      = UNIT_SH + MAX_CODE + 1;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned RA_W       = 3;
  localparam int unsigned NUM_CFG    = 2 * NUM_DYN_EP;
  localparam int unsigned NUM_REGION = NUM_CFG + 1;
  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned DBL_BIT    = 4;

  localparam logic [CODE_W-1:0] EP0_CODE = CODE_W'($clog2(EP0_BYTES) - UNIT_SH);

  localparam logic [RA_W-1:0] REG_INDEX    = 3'd0;
  localparam logic [RA_W-1:0] REG_TX_START = 3'd1;
  localparam logic [RA_W-1:0] REG_TX_SIZE  = 3'd2;
  localparam logic [RA_W-1:0] REG_RX_START = 3'd3;
  localparam logic [RA_W-1:0] REG_RX_SIZE  = 3'd4;

  // One FIFO configuration
  typedef struct packed {
    logic               en;
    logic               dbl;
    logic [CODE_W-1:0]  code;
    logic [START_W-1:0] start;
  } epCfg_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              wrStart;
    logic              wrSize;
    logic              dirRx;
    logic [RA_W-1:0]   sel;
    logic [EP_W-1:0]   ep;
    logic [REG_W-1:0]  data;
  } cfgStrobe_t;

  function automatic logic [OFF_W-1:0] pktBytes(input logic [CODE_W-1:0] code);
    return OFF_W'(UNIT_BYTES) << code;
  endfunction
endpackage

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl
  import ep_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWrData,
  output cfgStrobe_t       strobe
);
  logic [EP_W-1:0] curIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curIdx <= '0;
    else if (regWrEn && regAddr == REG_INDEX) curIdx <= regWrData[EP_W-1:0];
  end

  always_comb begin
    strobe.wrStart = regWrEn && (regAddr == REG_TX_START || regAddr == REG_RX_START);
    strobe.wrSize  = regWrEn && (regAddr == REG_TX_SIZE  || regAddr == REG_RX_SIZE);
    strobe.dirRx   = (regAddr == REG_RX_START || regAddr == REG_RX_SIZE);
    strobe.sel     = regAddr;
    strobe.ep      = curIdx;
    strobe.data    = regWrData;
  end
endmodule

// File: rtl/ep_fifo_cfg.sv
module ep_fifo_cfg
  import ep_fifo_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strobe,
  output epCfg_t [NUM_CFG-1:0]      cfgVec,
  output logic   [REG_W-1:0]        rdData,
  output logic                      cfgErr
);
  logic unusedData;
  assign unusedData = ^strobe.data[REG_W-1:START_W];

  // Storage: entries 0..N-1 transmit, N..2N-1 receive
  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_store
    localparam logic [EP_W-1:0] MY_EP = EP_W'(gi % NUM_DYN_EP + 1);
    localparam logic            MY_RX = (gi >= NUM_DYN_EP);
    epCfg_t entry;
    logic   hit;
    assign hit = (strobe.ep == MY_EP) && (strobe.dirRx == MY_RX);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entry <= '0;
      else if (hit && strobe.wrStart) entry.start <= strobe.data[START_W-1:0];
      else if (hit && strobe.wrSize) begin
        entry.en   <= strobe.data[EN_BIT];
        entry.dbl  <= strobe.data[DBL_BIT];
        entry.code <= strobe.data[CODE_W-1:0];
      end
    end
    assign cfgVec[gi] = entry;
  end

  // Region bounds: region 0 is the fixed endpoint 0 FIFO
  logic [ADDR_W:0]       rgBase [NUM_REGION];
  logic [ADDR_W:0]       rgEnd  [NUM_REGION];
  logic [NUM_REGION-1:0] rgOn;

  assign rgBase[0] = '0;
  assign rgEnd[0]  = (ADDR_W+1)'(EP0_BYTES);
  assign rgOn[0]   = 1'b1;

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_region
    logic [ADDR_W:0] span;
    assign span           = (ADDR_W+1)'(pktBytes(cfgVec[gi].code)) << cfgVec[gi].dbl;
    assign rgBase[gi+1]   = (ADDR_W+1)'({cfgVec[gi].start, {UNIT_SH{1'b0}}});
    assign rgEnd[gi+1]    = rgBase[gi+1] + span;
    assign rgOn[gi+1]     = cfgVec[gi].en;
  end

  logic [NUM_REGION-1:0]            overEnd;
  logic [NUM_REGION*NUM_REGION-1:0] clash;

  for (genvar ga = 0; ga < NUM_REGION; ga++) begin : g_chk_a
    assign overEnd[ga] = rgOn[ga] && (rgEnd[ga] > (ADDR_W+1)'(RAM_BYTES));
    for (genvar gb = 0; gb < NUM_REGION; gb++) begin : g_chk_b
      if (gb > ga) begin : g_pair
        assign clash[ga*NUM_REGION+gb] = rgOn[ga] && rgOn[gb] &&
                                         (rgBase[ga] < rgEnd[gb]) && (rgBase[gb] < rgEnd[ga]);
      end else begin : g_none
        assign clash[ga*NUM_REGION+gb] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= cfgErr | (|overEnd) | (|clash);
  end

  // Readback through the indexed window
  epCfg_t selCfg;
  logic   isDyn;
  logic   isEp0;

  always_comb begin
    selCfg = '0;
    isEp0  = (strobe.ep == '0);
    isDyn  = !isEp0 && (strobe.ep <= EP_W'(NUM_DYN_EP));
    for (int k = 0; k < NUM_CFG; k++) begin
      if (EP_W'(k % NUM_DYN_EP + 1) == strobe.ep && (k >= NUM_DYN_EP) == strobe.dirRx)
        selCfg = cfgVec[k];
    end
    rdData = '0;
    case (strobe.sel)
      REG_INDEX: rdData = REG_W'(strobe.ep);
      REG_TX_START, REG_RX_START: begin
        if (isDyn) rdData = REG_W'(selCfg.start);
      end
      REG_TX_SIZE, REG_RX_SIZE: begin
        if (isEp0) begin
          rdData[EN_BIT]       = 1'b1;
          rdData[CODE_W-1:0]   = EP0_CODE;
        end else if (isDyn) begin
          rdData[EN_BIT]       = selCfg.en;
          rdData[DBL_BIT]      = selCfg.dbl;
          rdData[CODE_W-1:0]   = selCfg.code;
        end
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ep_fifo_xlate.sv
module ep_fifo_xlate
  import ep_fifo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic [EP_W-1:0]      accEp,
  input  logic                 accDir,
  input  logic [OFF_W-1:0]     accOffset,
  input  logic                 accBufSel,
  input  epCfg_t [NUM_CFG-1:0] cfgVec,
  output logic                 ramEn,
  output logic [ADDR_W-1:0]    ramAddr,
  output logic                 rangeErr
);
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  limit;
  logic              dblOn;
  logic              known;
  logic              inRange;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    base  = '0;
    limit = OFF_W'(EP0_BYTES);
    dblOn = 1'b0;
    known = (accEp <= EP_W'(NUM_DYN_EP));
    for (int k = 0; k < NUM_CFG; k++) begin
      if (EP_W'(k % NUM_DYN_EP + 1) == accEp && (k >= NUM_DYN_EP) == accDir) begin
        base  = {cfgVec[k].start, {UNIT_SH{1'b0}}};
        limit = pktBytes(cfgVec[k].code);
        dblOn = cfgVec[k].dbl;
      end
    end
    inRange = known && (accOffset < limit);
    sum = base + ((accBufSel && dblOn) ? ADDR_W'(limit) : '0) + ADDR_W'(accOffset);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEn    <= 1'b0;
      ramAddr  <= '0;
      rangeErr <= 1'b0;
    end else begin
      ramEn    <= accValid && inRange;
      rangeErr <= accValid && !inRange;
      ramAddr  <= (accValid && inRange) ? sum : '0;
    end
  end
endmodule

// File: rtl/ep_fifo_alloc.sv
module ep_fifo_alloc
  import ep_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              accValid,
  input  logic [EP_W-1:0]   accEp,
  input  logic              accDir,
  input  logic [OFF_W-1:0]  accOffset,
  input  logic              accBufSel,
  output logic              ramEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              rangeErr,
  output logic              cfgErr
);
  cfgStrobe_t           strobe;
  epCfg_t [NUM_CFG-1:0] cfgVec;

  ep_fifo_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  ep_fifo_cfg u_cfg (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgVec (cfgVec),
    .rdData (regRdData),
    .cfgErr (cfgErr)
  );

  ep_fifo_xlate u_xlate (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accEp     (accEp),
    .accDir    (accDir),
    .accOffset (accOffset),
    .accBufSel (accBufSel),
    .cfgVec    (cfgVec),
    .ramEn     (ramEn),
    .ramAddr   (ramAddr),
    .rangeErr  (rangeErr)
  );
endmodule

// File: rtl/ep_fifo_alloc_chk.sv
module ep_fifo_alloc_chk
  import ep_fifo_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [EP_W-1:0]   accEp,
  input logic [OFF_W-1:0]  accOffset,
  input logic              ramEn,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              rangeErr,
  input logic              cfgErr
);
  // R7
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramEn && rangeErr));

  // R4
  answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> (ramEn || rangeErr));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!ramEn && !rangeErr));

  // R6
  ep0_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accEp == '0 && accOffset < OFF_W'(EP0_BYTES))
      |=> (ramEn && ramAddr == ADDR_W'($past(accOffset))));

  // R7
  bad_ep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accEp > EP_W'(NUM_DYN_EP)) |=> (rangeErr && !ramEn));

  // R7
  blocked_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramEn |-> (ramAddr == '0));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

bind ep_fifo_alloc ep_fifo_alloc_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accEp     (accEp),
  .accOffset (accOffset),
  .ramEn     (ramEn),
  .ramAddr   (ramAddr),
  .rangeErr  (rangeErr),
  .cfgErr    (cfgErr)
);

// File: tb/tb_ep_fifo_alloc.sv
`timescale 1ns/1ps
module tb_ep_fifo_alloc;
  import ep_fifo_pkg::*;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWrEn;
  logic [RA_W-1:0]   regAddr;
  logic [REG_W-1:0]  regWrData;
  logic [REG_W-1:0]  regRdData;
  logic              accValid;
  logic [EP_W-1:0]   accEp;
  logic              accDir;
  logic [OFF_W-1:0]  accOffset;
  logic              accBufSel;
  logic              ramEn;
  logic [ADDR_W-1:0] ramAddr;
  logic              rangeErr;
  logic              cfgErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ep_fifo_alloc dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accEp(accEp), .accDir(accDir), .accOffset(accOffset),
    .accBufSel(accBufSel), .ramEn(ramEn), .ramAddr(ramAddr),
    .rangeErr(rangeErr), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    accValid = 1'b0; accEp = '0; accDir = 1'b0; accOffset = '0; accBufSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [RA_W-1:0] a, input logic [REG_W-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [RA_W-1:0] a, output logic [REG_W-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic acc(input logic [EP_W-1:0] ep, input logic dir,
                     input logic [OFF_W-1:0] off, input logic bsel);
    accEp = ep; accDir = dir; accOffset = off; accBufSel = bsel; accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [REG_W-1:0] v;
    check("R1", "cfgErr", cfgErr, 0);
    check("R1", "ramEn", ramEn, 0);
    check("R1", "rangeErr", rangeErr, 0);
    rd(REG_INDEX, v); check("R1", "index", v, 0);
    wr(REG_INDEX, 16'd1);
    rd(REG_TX_SIZE, v);  check("R1", "ep1 tx size", v, 0);
    rd(REG_RX_START, v); check("R1", "ep1 rx start", v, 0);
  endtask

  task automatic testWindow();
    logic [REG_W-1:0] v;
    wr(REG_INDEX, 16'd1);
    wr(REG_TX_START, 16'd8);   wr(REG_TX_SIZE, 16'h0083);
    wr(REG_RX_START, 16'd16);  wr(REG_RX_SIZE, 16'h0094);
    wr(REG_INDEX, 16'd2);
    wr(REG_TX_START, 16'd48);  wr(REG_TX_SIZE, 16'h0087);
    rd(REG_TX_START, v); check("R2", "ep2 tx start", v, 48);
    rd(REG_TX_SIZE, v);  check("R2", "ep2 tx size", v, 16'h87);
    wr(REG_INDEX, 16'd1);
    rd(REG_INDEX, v);    check("R2", "index", v, 1);
    rd(REG_TX_START, v); check("R2", "ep1 tx start", v, 8);
    rd(REG_TX_SIZE, v);  check("R2", "ep1 tx size", v, 16'h83);
    rd(REG_RX_START, v); check("R2", "ep1 rx start", v, 16);
    rd(REG_RX_SIZE, v);  check("R2", "ep1 rx size", v, 16'h94);
    rd(3'd6, v);         check("R2", "offset 6 reads zero", v, 0);
    settle();
    check("R9", "adjacent regions legal", cfgErr, 0);
  endtask

  task automatic testTranslate();
    acc(3'd1, 1'b0, 11'd5, 1'b0);
    check("R4", "ep1 tx en", ramEn, 1);   check("R4", "ep1 tx addr", ramAddr, 69);
    acc(3'd2, 1'b0, 11'd1000, 1'b0);
    check("R4", "ep2 tx addr", ramAddr, 1384);
    acc(3'd1, 1'b1, 11'd3, 1'b0);
    check("R5", "ep1 rx buf0", ramAddr, 131);
    acc(3'd1, 1'b1, 11'd3, 1'b1);
    check("R5", "ep1 rx buf1", ramAddr, 259);
    acc(3'd1, 1'b0, 11'd5, 1'b1);
    check("R5", "single buffer ignores select", ramAddr, 69);
    @(negedge clk);
    check("R4", "idle ramEn", ramEn, 0);
  endtask

  task automatic testEp0();
    logic [REG_W-1:0] v;
    wr(REG_INDEX, 16'd0);
    rd(REG_TX_START, v); check("R3", "ep0 start", v, 0);
    rd(REG_TX_SIZE, v);  check("R3", "ep0 tx size", v, 16'h83);
    rd(REG_RX_SIZE, v);  check("R3", "ep0 rx size", v, 16'h83);
    wr(REG_TX_START, 16'd100); wr(REG_TX_SIZE, 16'h0007);
    rd(REG_TX_START, v); check("R3", "ep0 start after write", v, 0);
    rd(REG_TX_SIZE, v);  check("R3", "ep0 size after write", v, 16'h83);
    wr(REG_INDEX, 16'd6);
    wr(REG_RX_START, 16'd5);
    rd(REG_RX_START, v); check("R3", "index 6 reads zero", v, 0);
    wr(REG_INDEX, 16'd1);
    rd(REG_TX_START, v); check("R3", "ep1 untouched", v, 8);
    acc(3'd0, 1'b0, 11'd63, 1'b0);
    check("R6", "ep0 last byte en", ramEn, 1); check("R6", "ep0 addr", ramAddr, 63);
    acc(3'd0, 1'b1, 11'd10, 1'b1);
    check("R6", "ep0 select ignored", ramAddr, 10);
    acc(3'd0, 1'b0, 11'd64, 1'b0);
    check("R6", "ep0 offset 64 blocked", rangeErr, 1);
  endtask

  task automatic testRange();
    acc(3'd1, 1'b0, 11'd64, 1'b0);
    check("R7", "offset=mps en", ramEn, 0);
    check("R7", "offset=mps flag", rangeErr, 1);
    check("R7", "blocked addr", ramAddr, 0);
    acc(3'd1, 1'b1, 11'd127, 1'b0);
    check("R7", "last rx byte", ramAddr, 255);
    check("R7", "last rx byte flag", rangeErr, 0);
    acc(3'd2, 1'b0, 11'd1023, 1'b0);
    check("R7", "largest packet last byte", ramAddr, 1407);
    acc(3'd2, 1'b0, 11'd1024, 1'b0);
    check("R7", "largest packet overrun", rangeErr, 1);
    acc(3'd5, 1'b0, 11'd0, 1'b0);
    check("R7", "endpoint 5 blocked", rangeErr, 1);
    @(negedge clk);
    check("R7", "flag lasts one cycle", rangeErr, 0);
  endtask

  task automatic testSize();
    wr(REG_INDEX, 16'd3);
    wr(REG_TX_START, 16'd400);
    wr(REG_TX_SIZE, 16'h0007);
    settle();
    check("R10", "disabled overrun ignored", cfgErr, 0);
    wr(REG_TX_SIZE, 16'h0087);
    settle();
    check("R8", "overrun past 4096", cfgErr, 1);
    wr(REG_TX_SIZE, 16'h0007);
    settle();
    check("R10", "flag sticky after fix", cfgErr, 1);
  endtask

  task automatic testOverlap();
    doReset();
    wr(REG_INDEX, 16'd2);
    wr(REG_RX_START, 16'd384); wr(REG_RX_SIZE, 16'h0087);
    settle();
    check("R8", "end exactly 4096 legal", cfgErr, 0);
    wr(REG_INDEX, 16'd1);
    wr(REG_TX_START, 16'd8);   wr(REG_TX_SIZE, 16'h0083);
    settle();
    check("R9", "ep1 tx clean", cfgErr, 0);
    wr(REG_RX_START, 16'd12);  wr(REG_RX_SIZE, 16'h0083);
    settle();
    check("R9", "tx/rx same endpoint overlap", cfgErr, 1);

    doReset();
    wr(REG_INDEX, 16'd1);
    wr(REG_TX_START, 16'd4);   wr(REG_TX_SIZE, 16'h0083);
    settle();
    check("R9", "overlap with ep0", cfgErr, 1);

    doReset();
    wr(REG_INDEX, 16'd4);
    wr(REG_RX_START, 16'd28);  wr(REG_RX_SIZE, 16'h0083);
    wr(REG_TX_START, 16'd16);  wr(REG_TX_SIZE, 16'h0083);
    settle();
    check("R9", "single buffers clean", cfgErr, 0);
    wr(REG_TX_SIZE, 16'h0093);
    settle();
    check("R9", "double buffer causes overlap", cfgErr, 1);
  endtask

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    testReset();
    testWindow();
    testTranslate();
    testEp0();
    testRange();
    testSize();
    testOverlap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule